// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block turns a pixel clock into the four timing strobes of a video raster: a horizontal blank and a horizontal sync that repeat every line, and a vertical blank and a vertical sync that are decided once per line, or once per half-line. Every edge comes from a programmable value. A pixel counter runs from 1 to the line length. A vertical counter runs from 1 to the frame length. Each output is a comparison of one of these counters against its start and end values.

The block is built into a display pipeline. Software or a configuration block holds the eight timing values steady. A mode bit selects progressive or interlaced scanning. In interlaced mode the vertical counter steps twice per line, at the end of the line and at its midpoint, so the vertical values are given in half-lines while the frame length stays in whole lines. Two strobes mark the first pixel of every line and the first pixel of every frame, so downstream logic can align to the raster.

All outputs are registered. Output cycle k after reset release presents pixel k of the raster: the first rising edge with reset high presents pixel 1 of line 1.

Top module: `raster_sync_gen`

## Requirements
- R1: The pixel position runs 1, 2, ..., `line_len`, then goes back to 1, so a line lasts exactly `line_len` clocks. `line_start` is high for exactly the output cycle that presents pixel 1. `line_len` must be even and at least 2.
- R2: `hblank_n` is low for pixels 1 to `hblank_end`−1, so the blank is `hblank_end`−1 clocks wide. It is high for every other pixel.
- R3: `hsync_n` is low for pixels `hsync_start` to `hsync_end`−1 and high for every other pixel. The front porch is therefore `hsync_start`−1 clocks wide, and the sync is `hsync_end`−`hsync_start` clocks wide.
- R4: With `interlace`=0, the vertical unit is one line and the line number runs 1 to `frame_lines`, then goes back to 1. `frame_start` is high only in the output cycle of pixel 1 of line 1.
- R5: `vblank_n` reflects vertical units 1 to `vblank_end`−1 as low. `vsync_n` reflects units `vsync_start` to `vsync_end`−1 as low. Each output takes its value from the unit that is current at its update point.
- R6: `vblank_n` updates only at pixel 1. With `interlace`=1 it also updates at pixel `line_len`/2+1. It holds its value at every other pixel.
- R7: `vsync_n` updates only at pixel `hsync_start`, which is the leading edge of the horizontal sync. With `interlace`=1 it also updates at pixel `hsync_start`+`line_len`/2. It holds its value at every other pixel.
- R8: With `interlace`=1, the vertical unit is a half-line. The unit counter advances after pixel `line_len`/2 and after pixel `line_len`. It runs from 1 to 2×`frame_lines`, and `frame_start` marks pixel 1 of unit 1.
- R9: While `rst_n` is low at a clock edge, the block sets `hblank_n`=0, `vblank_n`=0, `hsync_n`=1, `vsync_n`=1, and `line_start`=`frame_start`=0. Both counters are reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| interlace | input | 1 | 1 selects half-line vertical timing |
| hsync_start | input | 16 | First pixel of horizontal sync |
| hsync_end | input | 16 | First pixel after horizontal sync |
| hblank_end | input | 16 | First pixel after horizontal blank |
| line_len | input | 16 | Pixels per line, even |
| vsync_start | input | 16 | First vertical unit of vertical sync |
| vsync_end | input | 16 | First vertical unit after vertical sync |
| vblank_end | input | 16 | First vertical unit after vertical blank |
| frame_lines | input | 16 | Whole lines per frame |
| hblank_n | output | 1 | Horizontal blank, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vblank_n | output | 1 | Vertical blank, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| line_start | output | 1 | High on pixel 1 of each line |
| frame_start | output | 1 | High on pixel 1 of the frame |

## Verification
The risky coincidence is in interlaced mode. The mid-line step of the vertical counter can fall on the same clock as a vertical update point: with `hsync_start` equal to `line_len`/2+1, the vertical sync decision is taken in the very cycle that the new half-line becomes current. Likewise, with `hsync_start` at 1, the frame wrap and the vertical sync update land together at pixel 1. Directed configurations force both cases, and random configurations cover the general spread. A bench reference walks the raster pixel by pixel, and every output is compared in every cycle, so a decision taken one half-line early or late shows up as a mismatch on `vsync_n` or `vblank_n`.

// File: rtl/raster_sync_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the raster sync generator.
// Assumes all timing values use the same width.
package raster_sync_pkg;
    localparam int unsigned TW = 16;   // width of every timing value
    typedef logic [TW-1:0]  tval_t;    // one timing value
    typedef logic [TW:0]    tsum_t;    // timing value plus one bit of headroom
endpackage

// File: rtl/rs_hcount.sv
`timescale 1ns/1ps
// Pixel counter: runs 1..line_len and flags the points where the vertical
// logic must advance or update. Assumes line_len is even and >= 2.
module rs_hcount #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         interlace,
    input  logic [W-1:0] line_len,
    input  logic [W-1:0] hsync_start,
    output logic [W-1:0] hcnt,
    output logic         line_end,
    output logic         mid_end,
    output logic         vb_upd,
    output logic         vs_upd
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] half;
    logic [W:0]   vs_mid;

    // Half-line position and the second vertical sync update point.
    always_comb begin
        half   = line_len >> 1;
        vs_mid = {1'b0, hsync_start} + {1'b0, half};
    end

    // Flags for the line end, the mid-line step and the update points.
    always_comb begin
        line_end = (hcnt >= line_len);
        mid_end  = interlace && (hcnt == half) && !line_end;
        vb_upd   = (hcnt == ONE) || (interlace && (hcnt == half + ONE));
        vs_upd   = (hcnt == hsync_start) || (interlace && ({1'b0, hcnt} == vs_mid));
    end

    // Pixel counter: reset to 1, wrap after line_len.
    always_ff @(posedge clk) begin
        if (!rst_n)        hcnt <= ONE;
        else if (line_end) hcnt <= ONE;
        else               hcnt <= hcnt + ONE;
    end
endmodule

// File: rtl/rs_vcount.sv
`timescale 1ns/1ps
// Vertical unit counter: runs 1..frame length, counted in lines when
// progressive and in half-lines when interlaced. Steps when advance is high.
module rs_vcount #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         interlace,
    input  logic [W-1:0] frame_lines,
    input  logic         advance,
    output logic [W:0]   vcnt
);
    localparam logic [W:0] ONE = (W+1)'(1);

    logic [W:0] vmax;

    // Frame length in vertical units for the selected mode.
    always_comb begin
        vmax = interlace ? {frame_lines, 1'b0} : {1'b0, frame_lines};
    end

    // Unit counter: reset to 1, wrap after vmax.
    always_ff @(posedge clk) begin
        if (!rst_n)              vcnt <= ONE;
        else if (advance) begin
            if (vcnt >= vmax)    vcnt <= ONE;
            else                 vcnt <= vcnt + ONE;
        end
    end
endmodule

// File: rtl/rs_vdecode.sv
`timescale 1ns/1ps
// Vertical output decode: samples the unit counter against the vertical
// window values, but only at the given update points, so each vertical
// edge lines up with a horizontal reference edge.
module rs_vdecode #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W:0]   vcnt,
    input  logic [W-1:0] vsync_start,
    input  logic [W-1:0] vsync_end,
    input  logic [W-1:0] vblank_end,
    input  logic         vb_upd,
    input  logic         vs_upd,
    output logic         vblank_n,
    output logic         vsync_n
);
    logic in_vblank;
    logic in_vsync;

    // Window membership of the current vertical unit.
    always_comb begin
        in_vblank = (vcnt < {1'b0, vblank_end});
        in_vsync  = (vcnt >= {1'b0, vsync_start}) && (vcnt < {1'b0, vsync_end});
    end

    // Vertical blank register: loaded only at its update points.
    always_ff @(posedge clk) begin
        if (!rst_n)      vblank_n <= 1'b0;
        else if (vb_upd) vblank_n <= !in_vblank;
    end

    // Vertical sync register: loaded only at the horizontal sync start points.
    always_ff @(posedge clk) begin
        if (!rst_n)      vsync_n <= 1'b1;
        else if (vs_upd) vsync_n <= !in_vsync;
    end
endmodule

// File: rtl/raster_sync_gen.sv
`timescale 1ns/1ps
// Programmable raster sync timing generator (top).
// Outputs are registered; output cycle k after reset presents pixel k.
// Assumes the timing values are held steady outside reset, line_len is
// even and >= 2, and frame_lines >= 1.
module raster_sync_gen
    import raster_sync_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        interlace,
    input  logic [15:0] hsync_start,
    input  logic [15:0] hsync_end,
    input  logic [15:0] hblank_end,
    input  logic [15:0] line_len,
    input  logic [15:0] vsync_start,
    input  logic [15:0] vsync_end,
    input  logic [15:0] vblank_end,
    input  logic [15:0] frame_lines,
    output logic        hblank_n,
    output logic        hsync_n,
    output logic        vblank_n,
    output logic        vsync_n,
    output logic        line_start,
    output logic        frame_start
);
    localparam int unsigned W = TW;

    tval_t      hcnt;
    tsum_t      vcnt;
    logic       line_end, mid_end, vb_upd, vs_upd;

    rs_hcount #(.W(W)) u_hcount (
        .clk(clk), .rst_n(rst_n), .interlace(interlace),
        .line_len(line_len), .hsync_start(hsync_start),
        .hcnt(hcnt), .line_end(line_end), .mid_end(mid_end),
        .vb_upd(vb_upd), .vs_upd(vs_upd)
    );

    rs_vcount #(.W(W)) u_vcount (
        .clk(clk), .rst_n(rst_n), .interlace(interlace),
        .frame_lines(frame_lines), .advance(line_end || mid_end),
        .vcnt(vcnt)
    );

    rs_vdecode #(.W(W)) u_vdecode (
        .clk(clk), .rst_n(rst_n), .vcnt(vcnt),
        .vsync_start(vsync_start), .vsync_end(vsync_end),
        .vblank_end(vblank_end), .vb_upd(vb_upd), .vs_upd(vs_upd),
        .vblank_n(vblank_n), .vsync_n(vsync_n)
    );

    // Horizontal outputs and strobes registered from the pixel position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hblank_n    <= 1'b0;
            hsync_n     <= 1'b1;
            line_start  <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            hblank_n    <= !(hcnt < hblank_end);
            hsync_n     <= !((hcnt >= hsync_start) && (hcnt < hsync_end));
            line_start  <= (hcnt == tval_t'(1));
            frame_start <= (hcnt == tval_t'(1)) && (vcnt == tsum_t'(1));
        end
    end
endmodule

// File: rtl/raster_sync_gen_chk.sv
`timescale 1ns/1ps
// Checker for raster_sync_gen: counter ranges and edge alignment.
module raster_sync_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        interlace,
    input logic [15:0] line_len,
    input logic [15:0] frame_lines,
    input logic [15:0] hcnt,
    input logic [16:0] vcnt,
    input logic        hsync_n,
    input logic        vblank_n,
    input logic        vsync_n,
    input logic        line_start
);
    // R1: the pixel counter goes back to 1 after the last pixel.
    p_hcnt_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt >= line_len) |=> (hcnt == 16'd1));

    // R1: below the line length the pixel counter steps by one.
    p_hcnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt < line_len) |=> (hcnt == $past(hcnt) + 16'd1));

    // R4: when progressive, the line number holds within a line.
    p_vcnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!interlace && hcnt < line_len) |=> $stable(vcnt));

    // R8: the unit counter stays within the frame for the selected mode.
    p_vcnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vcnt >= 17'd1) && (vcnt <= (interlace ? {frame_lines, 1'b0} : {1'b0, frame_lines})));

    // R6: when progressive, vertical blank moves only on a line-start cycle.
    p_vblank_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!interlace && !$stable(vblank_n)) |-> line_start);

    // R7: when progressive, vertical sync moves only with a falling horizontal sync.
    p_vsync_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!interlace && !$stable(vsync_n)) |-> $fell(hsync_n));
endmodule

bind raster_sync_gen raster_sync_gen_chk i_chk (
    .clk(clk), .rst_n(rst_n), .interlace(interlace),
    .line_len(line_len), .frame_lines(frame_lines),
    .hcnt(hcnt), .vcnt(vcnt), .hsync_n(hsync_n),
    .vblank_n(vblank_n), .vsync_n(vsync_n), .line_start(line_start)
);

// File: tb/test_raster_sync_gen.sv
`timescale 1ns/1ps
// Bench: directed and seeded random timing configurations, every output
// compared every cycle against a pixel-walking reference built from R1..R9.
module test_raster_sync_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        il = 1'b0;
    logic [15:0] r_hs = 16'd2, r_he = 16'd3, r_hb = 16'd4, r_len = 16'd8;
    logic [15:0] r_vs = 16'd2, r_ve = 16'd3, r_vb = 16'd4, r_fl = 16'd6;
    logic        hblank_n, hsync_n, vblank_n, vsync_n, line_start, frame_start;

    int unsigned n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    // reference state
    int  mh, mv;
    bit  e_hb, e_hs, e_vb, e_vs, e_ls, e_fs, in_rst;

    always #2.5 clk = ~clk;

    raster_sync_gen i_raster_sync_gen (
        .clk(clk), .rst_n(rst_n), .interlace(il),
        .hsync_start(r_hs), .hsync_end(r_he), .hblank_end(r_hb), .line_len(r_len),
        .vsync_start(r_vs), .vsync_end(r_ve), .vblank_end(r_vb), .frame_lines(r_fl),
        .hblank_n(hblank_n), .hsync_n(hsync_n), .vblank_n(vblank_n), .vsync_n(vsync_n),
        .line_start(line_start), .frame_start(frame_start)
    );

    function automatic int units_per_frame(bit i, int fl);
        return i ? 2 * fl : fl;
    endfunction

    // Reference walk of the raster, one pixel per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            in_rst = 1'b1;
            mh = 1; mv = 1;
            e_hb = 0; e_hs = 1; e_vb = 0; e_vs = 1; e_ls = 0; e_fs = 0;
        end else begin
            in_rst = 1'b0;
            e_hb = !(mh < int'(r_hb));
            e_hs = !(mh >= int'(r_hs) && mh < int'(r_he));
            e_ls = (mh == 1);
            e_fs = (mh == 1) && (mv == 1);
            if (mh == 1 || (il && mh == int'(r_len) / 2 + 1))
                e_vb = !(mv < int'(r_vb));
            if (mh == int'(r_hs) || (il && mh == int'(r_hs) + int'(r_len) / 2))
                e_vs = !(mv >= int'(r_vs) && mv < int'(r_ve));
            if (mh >= int'(r_len) || (il && mh == int'(r_len) / 2)) begin
                mv = (mv >= units_per_frame(il, int'(r_fl))) ? 1 : mv + 1;
            end
            mh = (mh >= int'(r_len)) ? 1 : mh + 1;
        end
    end

    task automatic chk(input bit act, input bit exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
        end
    endtask

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        if (!done && $time > 10) begin
            if (in_rst) begin
                chk(hblank_n, 1'b0, "R9 hblank_n");
                chk(hsync_n, 1'b1, "R9 hsync_n");
                chk(vblank_n, 1'b0, "R9 vblank_n");
                chk(vsync_n, 1'b1, "R9 vsync_n");
                chk(line_start | frame_start, 1'b0, "R9 strobes");
            end else begin
                chk(hblank_n, e_hb, "R2 hblank_n");
                chk(hsync_n, e_hs, "R3 hsync_n");
                chk(vblank_n, e_vb, "R5/R6 vblank_n");
                chk(vsync_n, e_vs, "R5/R7 vsync_n");
                chk(line_start, e_ls, "R1 line_start");
                chk(frame_start, e_fs, il ? "R8 frame_start" : "R4 frame_start");
            end
        end
    end

    // Apply one configuration under reset and run a given number of frames.
    task automatic run_cfg(input bit i, input int len, input int hs, input int he,
                           input int hb, input int fl, input int vs, input int ve,
                           input int vb, input int frames);
        @(posedge clk); #1;
        rst_n = 1'b0;
        il = i;
        r_len = 16'(len); r_hs = 16'(hs); r_he = 16'(he); r_hb = 16'(hb);
        r_fl = 16'(fl); r_vs = 16'(vs); r_ve = 16'(ve); r_vb = 16'(vb);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (frames * len * fl + 3) @(posedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        // R1 R2 R3 R4 R5 R6 R7: plain progressive raster
        run_cfg(0, 12, 3, 5, 7, 8, 2, 4, 5, 2);
        // R8: interlaced, sync decision on the mid-line step cycle
        run_cfg(1, 12, 7, 9, 10, 5, 3, 6, 7, 2);
        // R7 R8: sync start at pixel 1, shared with the frame wrap
        run_cfg(1, 10, 1, 3, 4, 4, 1, 3, 4, 2);
        // R2 R5: blank covering whole line, no vertical blank
        run_cfg(0, 8, 2, 4, 9, 5, 2, 3, 1, 2);
        // R8: sync start at half-line, second point lands on the last pixel
        run_cfg(1, 16, 8, 10, 12, 6, 4, 7, 9, 2);
        // random configurations
        for (int k = 0; k < 12; k++) begin
            int len, hs, he, hb, fl, u, vs, ve, vb;
            bit i;
            i   = $urandom % 2;
            len = 2 * (4 + $urandom % 17);
            hs  = 2 + $urandom % (len / 2 - 1);
            he  = hs + 1 + $urandom % 4;
            hb  = he + $urandom % (len - he + 1);
            fl  = 4 + $urandom % 13;
            u   = units_per_frame(i, fl);
            vs  = 2 + $urandom % (u / 2 - 1);
            ve  = vs + 1 + $urandom % 3;
            vb  = ve + $urandom % (u - ve + 1);
            run_cfg(i, len, hs, he, hb, fl, vs, ve, vb, 2);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5 * 190000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule